// File: doc/BRIEF.md
# Four-Way Address Translation Lookup

This block turns a 32-bit virtual address into a physical address through a four-way set-associative translation buffer. Bits 16..12 of the virtual address select one of 32 sets. The entry of that set in all four ways is read and compared in parallel against the upper virtual page bits, the page-size-dependent low page bits and the current address-space identifier (ASID). A lookup strobe produces a registered response one clock later. The response carries a hit flag, the number of the way that hit, a flag for more than one hit, the physical address and the page attributes of the hitting entry.

Entries are loaded through a write port that names a way and a set. A global invalidate input clears every valid bit. Each entry holds the page size, a shared flag, a 2-bit protection field, a cacheable flag and a dirty flag. The page size and shared flag, together with a single-versus-multiple address-space mode input, decide which fields take part in the compare. The block does not walk page tables, raise exceptions, check protection or choose a victim way.

Top module: `tlb4w_lookup`

## Requirements
- R1: After reset, `rsp_vld` and `rsp_hit` are 0 and every entry is invalid, so any lookup misses until an entry is written.
- R2: `rsp_vld` is 1 in exactly the cycle after a cycle with `req_vld` = 1. The response reflects the table contents as they were before that clock edge.
- R3: A lookup uses set `req_va[16:12]`. A way can hit only when its entry in that set is valid and its stored upper page bits equal `req_va[31:17]`.
- R4: For a 1 KB page (`wr_big` = 0), the stored low page bits must equal `req_va[11:10]`, and `rsp_pa` = {stored PPN[21:0], `req_va[9:0]`}.
- R5: For a 4 KB page (`wr_big` = 1), the stored low page bits take no part in the compare, and `rsp_pa` = {stored PPN[21:2], `req_va[11:0]`}.
- R6: In multiple address-space mode (`mode_single` = 0), an entry with the shared flag set hits without its ASID being compared. An entry with the shared flag clear hits only when its ASID equals `cur_asid`.
- R7: In single address-space mode (`mode_single` = 1), the ASID is always compared, whatever the shared flag.
- R8: A write with `wr_en` = 1 stores all fields and the valid bit into entry (`wr_way`, `wr_idx`) at the clock edge. A lookup in the next cycle sees the new entry.
- R9: `inv_all` = 1 clears every valid bit at the clock edge. It overrides the valid bit of a write made in the same cycle.
- R10: When more than one way matches, `rsp_hit` and `rsp_multi` are 1 and `rsp_way` gives the lowest-numbered matching way, whose PA and attributes are output.
- R11: On a miss, `rsp_way`, `rsp_pa`, `rsp_prot` and all attribute flags are 0.
- R12: On a hit, `rsp_prot`, `rsp_big`, `rsp_cach`, `rsp_dirty` and `rsp_shr` equal the fields stored in the hitting entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_single | input | 1 | 1 = single address space (ASID always compared) |
| cur_asid | input | 8 | Current address-space identifier |
| req_vld | input | 1 | Lookup strobe |
| req_va | input | 32 | Virtual address to translate |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 2 | Way to write |
| wr_idx | input | 5 | Set to write |
| wr_vpn_hi | input | 15 | Virtual page bits 31..17 |
| wr_vpn_lo | input | 2 | Virtual page bits 11..10 |
| wr_asid | input | 8 | Entry ASID |
| wr_valid | input | 1 | Entry valid bit |
| wr_ppn | input | 22 | Physical page bits 31..10 |
| wr_prot | input | 2 | Protection field |
| wr_big | input | 1 | Page size: 0 = 1 KB, 1 = 4 KB |
| wr_cach | input | 1 | Cacheable flag |
| wr_dirty | input | 1 | Dirty flag |
| wr_shr | input | 1 | Shared flag |
| inv_all | input | 1 | Clear all valid bits |
| rsp_vld | output | 1 | Response valid, one cycle after `req_vld` |
| rsp_hit | output | 1 | At least one way matched |
| rsp_way | output | 2 | Lowest matching way |
| rsp_multi | output | 1 | More than one way matched |
| rsp_pa | output | 32 | Physical address |
| rsp_prot | output | 2 | Protection field of the hit entry |
| rsp_big | output | 1 | Page size of the hit entry |
| rsp_cach | output | 1 | Cacheable flag of the hit entry |
| rsp_dirty | output | 1 | Dirty flag of the hit entry |
| rsp_shr | output | 1 | Shared flag of the hit entry |

## Verification
Directed lookups change one field at a time against a known entry: the upper page bits, the set, the low page bits and the ASID. Each of these separates a correct compare from one that ignores or misplaces that field. The same changes are repeated on 4 KB and shared entries, in both address-space modes, to show when the low page bits and the ASID drop out of the compare. A write in the same cycle as a lookup shows the old and then the new contents, and a write made together with an invalidate must come out invalid. Two identical entries show lowest-way priority and the multi-hit flag. A long run of random writes, lookups and invalidates over a small tag space then compares every response with a behavioural model.

// File: rtl/tlb4w_pkg.sv
package tlb4w_pkg;

  localparam int VA_W    = 32;
  localparam int ASID_W  = 8;
  localparam int VHI_W   = 15;   // virtual page bits 31..17
  localparam int VLO_W   = 2;    // virtual page bits 11..10
  localparam int PPN_W   = 22;   // physical page bits 31..10
  localparam int PROT_W  = 2;

  typedef struct packed {
    logic [VHI_W-1:0]  vpn_hi;
    logic [VLO_W-1:0]  vpn_lo;
    logic [ASID_W-1:0] asid;
  } tag_t;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [PROT_W-1:0] prot;
    logic              big;
    logic              cach;
    logic              dirty;
    logic              shr;
  } attr_t;

  // Tag compare: low page bits drop out for 4 KB pages, ASID drops out for
  // shared pages unless a single address space is in force.
  function automatic logic tag_hit(input tag_t t, input logic vld,
                                   input logic big, input logic shr,
                                   input logic single,
                                   input logic [VHI_W-1:0] va_hi,
                                   input logic [VLO_W-1:0] va_lo,
                                   input logic [ASID_W-1:0] asid);
    logic hi_ok, lo_ok, id_ok;
    hi_ok = (t.vpn_hi == va_hi);
    lo_ok = big || (t.vpn_lo == va_lo);
    id_ok = (shr && !single) || (t.asid == asid);
    return vld && hi_ok && lo_ok && id_ok;
  endfunction

  // Physical address from page number and in-page offset.
  function automatic logic [VA_W-1:0] make_pa(input logic [PPN_W-1:0] ppn,
                                              input logic big,
                                              input logic [11:0] va_lo12);
    if (big) return {ppn[PPN_W-1:2], va_lo12};
    return {ppn, va_lo12[9:0]};
  endfunction

endpackage

// File: rtl/tlb4w_way.sv
module tlb4w_way
  import tlb4w_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tag_t             wr_tag,
  input  logic             wr_valid,
  input  attr_t            wr_attr,
  input  logic             inv_all,
  input  logic [IDX_W-1:0] rd_idx,
  output tag_t             rd_tag,
  output logic             rd_valid,
  output attr_t            rd_attr,
  output logic             any_valid
);

  localparam int SETS = 1 << IDX_W;

  tag_t            tag_mem  [SETS];
  attr_t           attr_mem [SETS];
  logic [SETS-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      attr_mem[wr_idx] <= wr_attr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       vld_q <= '0;
    else if (inv_all) vld_q <= '0;
    else if (wr_en)   vld_q[wr_idx] <= wr_valid;
  end

  assign rd_tag    = tag_mem[rd_idx];
  assign rd_attr   = attr_mem[rd_idx];
  assign rd_valid  = vld_q[rd_idx];
  assign any_valid = |vld_q;

endmodule

// File: rtl/tlb4w_sel.sv
module tlb4w_sel
  import tlb4w_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0]        match_vec,
  input  attr_t [NUM_WAYS-1:0]       attrs,
  output logic                       hit,
  output logic                       multi,
  output logic [WAY_W-1:0]           way,
  output attr_t                      attr
);

  always_comb begin
    hit   = |match_vec;
    multi = ($countones(match_vec) > 1);
    way   = '0;
    attr  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) begin
        way  = WAY_W'(w);
        attr = attrs[w];
      end
    end
  end

endmodule

// File: rtl/tlb4w_lookup.sv
module tlb4w_lookup
  import tlb4w_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int IDX_W    = 5,
  parameter int IDX_LSB  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_single,
  input  logic [ASID_W-1:0]    cur_asid,
  input  logic                 req_vld,
  input  logic [VA_W-1:0]      req_va,
  input  logic                 wr_en,
  input  logic [1:0]           wr_way,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [VHI_W-1:0]     wr_vpn_hi,
  input  logic [VLO_W-1:0]     wr_vpn_lo,
  input  logic [ASID_W-1:0]    wr_asid,
  input  logic                 wr_valid,
  input  logic [PPN_W-1:0]     wr_ppn,
  input  logic [PROT_W-1:0]    wr_prot,
  input  logic                 wr_big,
  input  logic                 wr_cach,
  input  logic                 wr_dirty,
  input  logic                 wr_shr,
  input  logic                 inv_all,
  output logic                 rsp_vld,
  output logic                 rsp_hit,
  output logic [1:0]           rsp_way,
  output logic                 rsp_multi,
  output logic [VA_W-1:0]      rsp_pa,
  output logic [PROT_W-1:0]    rsp_prot,
  output logic                 rsp_big,
  output logic                 rsp_cach,
  output logic                 rsp_dirty,
  output logic                 rsp_shr
);

  localparam int WAY_W = 2;

  tag_t                 wr_tag;
  attr_t                wr_attr;
  logic [IDX_W-1:0]     rd_idx;
  tag_t                 rd_tag   [NUM_WAYS];
  logic [NUM_WAYS-1:0]  rd_valid;
  attr_t [NUM_WAYS-1:0] rd_attr;

  // Named events for the checker.
  logic [NUM_WAYS-1:0]  match_vec;
  logic [NUM_WAYS-1:0]  valid_any;

  logic                 sel_hit;
  logic                 sel_multi;
  logic [WAY_W-1:0]     sel_way;
  attr_t                sel_attr;
  logic [VA_W-1:0]      sel_pa;

  assign wr_tag  = '{vpn_hi: wr_vpn_hi, vpn_lo: wr_vpn_lo, asid: wr_asid};
  assign wr_attr = '{ppn: wr_ppn, prot: wr_prot, big: wr_big,
                     cach: wr_cach, dirty: wr_dirty, shr: wr_shr};
  assign rd_idx  = req_va[IDX_LSB +: IDX_W];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb4w_way #(.IDX_W(IDX_W)) u_way (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en && (wr_way == WAY_W'(w))),
      .wr_idx    (wr_idx),
      .wr_tag    (wr_tag),
      .wr_valid  (wr_valid),
      .wr_attr   (wr_attr),
      .inv_all   (inv_all),
      .rd_idx    (rd_idx),
      .rd_tag    (rd_tag[w]),
      .rd_valid  (rd_valid[w]),
      .rd_attr   (rd_attr[w]),
      .any_valid (valid_any[w])
    );

    assign match_vec[w] = tag_hit(rd_tag[w], rd_valid[w], rd_attr[w].big,
                                  rd_attr[w].shr, mode_single,
                                  req_va[VA_W-1 -: VHI_W], req_va[11:10],
                                  cur_asid);
  end

  tlb4w_sel #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_sel (
    .match_vec (match_vec),
    .attrs     (rd_attr),
    .hit       (sel_hit),
    .multi     (sel_multi),
    .way       (sel_way),
    .attr      (sel_attr)
  );

  assign sel_pa = sel_hit ? make_pa(sel_attr.ppn, sel_attr.big, req_va[11:0])
                          : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_multi <= 1'b0;
      rsp_pa    <= '0;
      rsp_prot  <= '0;
      rsp_big   <= 1'b0;
      rsp_cach  <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_shr   <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
      if (req_vld) begin
        rsp_hit   <= sel_hit;
        rsp_way   <= sel_way;
        rsp_multi <= sel_multi;
        rsp_pa    <= sel_pa;
        rsp_prot  <= sel_attr.prot;
        rsp_big   <= sel_attr.big;
        rsp_cach  <= sel_attr.cach;
        rsp_dirty <= sel_attr.dirty;
        rsp_shr   <= sel_attr.shr;
      end
    end
  end

endmodule

// File: rtl/tlb4w_chk.sv
module tlb4w_chk #(
  parameter int NUM_WAYS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_vld,
  input logic                inv_all,
  input logic                rsp_vld,
  input logic                rsp_hit,
  input logic [1:0]          rsp_way,
  input logic                rsp_multi,
  input logic [31:0]         rsp_pa,
  input logic [NUM_WAYS-1:0] match_vec,
  input logic [NUM_WAYS-1:0] valid_any
);

  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);

  a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);

  a_r8_match_gives_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (match_vec != '0)) |=> rsp_hit);

  a_r9_inv_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_any == '0));

  a_r10_multi_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && ($countones(match_vec) > 1)) |=> (rsp_multi && rsp_hit));

  a_r10_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_multi) |-> rsp_hit);

  a_r11_miss_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && !rsp_hit) |-> ((rsp_pa == '0) && (rsp_way == '0) && !rsp_multi));

endmodule

bind tlb4w_lookup tlb4w_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .inv_all   (inv_all),
  .rsp_vld   (rsp_vld),
  .rsp_hit   (rsp_hit),
  .rsp_way   (rsp_way),
  .rsp_multi (rsp_multi),
  .rsp_pa    (rsp_pa),
  .match_vec (match_vec),
  .valid_any (valid_any)
);

// File: tb/tlb4w_lookup_tb.sv
`timescale 1ns/1ps
module tlb4w_lookup_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_single;
  logic [7:0]  cur_asid;
  logic        req_vld;
  logic [31:0] req_va;
  logic        wr_en;
  logic [1:0]  wr_way;
  logic [4:0]  wr_idx;
  logic [14:0] wr_vpn_hi;
  logic [1:0]  wr_vpn_lo;
  logic [7:0]  wr_asid;
  logic        wr_valid;
  logic [21:0] wr_ppn;
  logic [1:0]  wr_prot;
  logic        wr_big, wr_cach, wr_dirty, wr_shr;
  logic        inv_all;
  logic        rsp_vld, rsp_hit, rsp_multi;
  logic [1:0]  rsp_way;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_prot;
  logic        rsp_big, rsp_cach, rsp_dirty, rsp_shr;

  always #2.5 clk = ~clk;

  tlb4w_lookup dut_i (.*);

  int n_total = 0;
  int n_bad   = 0;

  // Behavioural model: plain arrays indexed [way][set].
  bit [14:0] m_vh [4][32];
  bit [1:0]  m_vl [4][32];
  bit [7:0]  m_as [4][32];
  bit        m_v  [4][32];
  bit [21:0] m_pp [4][32];
  bit [1:0]  m_pr [4][32];
  bit        m_sz [4][32], m_c [4][32], m_d [4][32], m_sh [4][32];

  bit        e_vld, e_hit, e_multi;
  bit [1:0]  e_way, e_prot;
  bit [31:0] e_pa;
  bit        e_big, e_c, e_d, e_sh;

  function automatic bit [31:0] mkva(bit [14:0] vh, bit [4:0] ix, bit [1:0] vl, bit [9:0] off);
    return {vh, ix, vl, off};
  endfunction

  task automatic predict();
    int ix, cnt, first;
    ix = int'(req_va[16:12]);
    cnt = 0; first = -1;
    for (int w = 0; w < 4; w++) begin
      bit ok;
      ok = m_v[w][ix] && (m_vh[w][ix] == req_va[31:17]);
      if (!m_sz[w][ix] && (m_vl[w][ix] != req_va[11:10])) ok = 0;
      if (!(m_sh[w][ix] && !mode_single) && (m_as[w][ix] != cur_asid)) ok = 0;
      if (ok) begin
        cnt++;
        if (first < 0) first = w;
      end
    end
    e_vld = req_vld;
    if (req_vld) begin
      e_hit = (cnt > 0); e_multi = (cnt > 1);
      if (cnt > 0) begin
        e_way  = 2'(first);
        e_prot = m_pr[first][ix]; e_big = m_sz[first][ix];
        e_c = m_c[first][ix]; e_d = m_d[first][ix]; e_sh = m_sh[first][ix];
        if (m_sz[first][ix]) e_pa = (32'(m_pp[first][ix]) << 10 & 32'hFFFF_F000) | (req_va & 32'h0000_0FFF);
        else                 e_pa = (32'(m_pp[first][ix]) << 10) | (req_va & 32'h0000_03FF);
      end else begin
        e_way = 0; e_prot = 0; e_big = 0; e_c = 0; e_d = 0; e_sh = 0; e_pa = 0;
      end
    end
  endtask

  task automatic model_update();
    if (wr_en) begin
      m_vh[wr_way][wr_idx] = wr_vpn_hi; m_vl[wr_way][wr_idx] = wr_vpn_lo;
      m_as[wr_way][wr_idx] = wr_asid;   m_pp[wr_way][wr_idx] = wr_ppn;
      m_pr[wr_way][wr_idx] = wr_prot;   m_sz[wr_way][wr_idx] = wr_big;
      m_c[wr_way][wr_idx]  = wr_cach;   m_d[wr_way][wr_idx]  = wr_dirty;
      m_sh[wr_way][wr_idx] = wr_shr;    m_v[wr_way][wr_idx]  = wr_valid;
    end
    if (inv_all)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 32; s++) m_v[w][s] = 0;
  endtask

  // One clock: predict from current inputs, advance model, compare after the edge.
  task automatic tick(string rq);
    predict();
    model_update();
    @(negedge clk);
    n_total++;
    if (rsp_vld !== e_vld) begin
      n_bad++;
      $display("FAIL %s rsp_vld act=%0b exp=%0b", rq, rsp_vld, e_vld);
    end else if (e_vld) begin
      if (rsp_hit !== e_hit || rsp_multi !== e_multi || rsp_way !== e_way ||
          rsp_pa !== e_pa || rsp_prot !== e_prot || rsp_big !== e_big ||
          rsp_cach !== e_c || rsp_dirty !== e_d || rsp_shr !== e_sh) begin
        n_bad++;
        $display("FAIL %s act hit=%0b multi=%0b way=%0d pa=%h attr=%b%b%b%b%b exp hit=%0b multi=%0b way=%0d pa=%h attr=%b%b%b%b%b",
                 rq, rsp_hit, rsp_multi, rsp_way, rsp_pa, rsp_prot, rsp_big, rsp_cach, rsp_dirty, rsp_shr,
                 e_hit, e_multi, e_way, e_pa, e_prot, e_big, e_c, e_d, e_sh);
      end
    end
    req_vld = 0; wr_en = 0; inv_all = 0;
  endtask

  task automatic set_wr(bit [1:0] w, bit [4:0] ix, bit [14:0] vh, bit [1:0] vl,
                        bit [7:0] asid, bit v, bit [21:0] pp, bit [1:0] pr,
                        bit sz, bit c, bit d, bit sh);
    wr_en = 1; wr_way = w; wr_idx = ix; wr_vpn_hi = vh; wr_vpn_lo = vl;
    wr_asid = asid; wr_valid = v; wr_ppn = pp; wr_prot = pr;
    wr_big = sz; wr_cach = c; wr_dirty = d; wr_shr = sh;
  endtask

  task automatic look(bit [31:0] va, string rq);
    req_vld = 1; req_va = va;
    tick(rq);
  endtask

  initial begin
    #(5.0 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; mode_single = 0; cur_asid = 8'h05; req_vld = 0; req_va = 0;
    wr_en = 0; wr_way = 0; wr_idx = 0; wr_vpn_hi = 0; wr_vpn_lo = 0; wr_asid = 0;
    wr_valid = 0; wr_ppn = 0; wr_prot = 0; wr_big = 0; wr_cach = 0; wr_dirty = 0;
    wr_shr = 0; inv_all = 0;
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 32; s++) m_v[w][s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_total++;
    if (rsp_vld !== 0 || rsp_hit !== 0) begin
      n_bad++;
      $display("FAIL R1 reset vld=%0b hit=%0b exp 0 0", rsp_vld, rsp_hit);
    end
    look(mkva(15'h0, 5'd3, 2'd1, 10'h0), "R1 miss after reset");
    tick("R2 idle no response");

    // 1 KB private entry, way 0 set 3
    set_wr(0, 3, 15'h1234, 2'd2, 8'h05, 1, 22'h2ABCD, 2'd3, 0, 1, 0, 0);
    tick("R8 write");
    look(mkva(15'h1234, 3, 2'd2, 10'h1A5), "R4 R12 hit 1KB");
    look(mkva(15'h1234, 3, 2'd1, 10'h1A5), "R4 low page bits differ");
    look(mkva(15'h1235, 3, 2'd2, 10'h1A5), "R3 upper bits differ");
    look(mkva(15'h1234, 4, 2'd2, 10'h1A5), "R3 other set");
    cur_asid = 8'h06;
    look(mkva(15'h1234, 3, 2'd2, 10'h1A5), "R6 asid differs private");
    cur_asid = 8'h05;

    // 4 KB shared entry, way 2 set 7
    set_wr(2, 7, 15'h0777, 2'd0, 8'h09, 1, 22'h13579, 2'd1, 1, 0, 1, 1);
    tick("R8 write");
    look(mkva(15'h0777, 7, 2'd3, 10'h3FF), "R5 hit 4KB any low bits");
    look(mkva(15'h0777, 7, 2'd1, 10'h001), "R5 R6 shared ignores asid");
    mode_single = 1;
    look(mkva(15'h0777, 7, 2'd1, 10'h001), "R7 single mode compares asid");
    cur_asid = 8'h09;
    look(mkva(15'h0777, 7, 2'd1, 10'h001), "R7 single mode asid equal");
    mode_single = 0; cur_asid = 8'h05;

    // write and lookup in the same cycle: old contents, then new
    set_wr(1, 9, 15'h00AA, 2'd0, 8'h05, 1, 22'h00F0F, 2'd2, 0, 1, 1, 0);
    req_vld = 1; req_va = mkva(15'h00AA, 9, 2'd0, 10'h055);
    tick("R2 lookup sees pre-write contents");
    look(mkva(15'h00AA, 9, 2'd0, 10'h055), "R8 lookup sees new entry");

    // duplicate tags in ways 1 and 3
    set_wr(3, 9, 15'h00AA, 2'd0, 8'h05, 1, 22'h3FFFF, 2'd0, 0, 0, 0, 0);
    tick("R8 write");
    look(mkva(15'h00AA, 9, 2'd0, 10'h055), "R10 multi hit lowest way");

    // invalidate, and invalidate overriding a simultaneous write
    inv_all = 1;
    tick("R9 invalidate");
    look(mkva(15'h1234, 3, 2'd2, 10'h1A5), "R9 R11 miss after invalidate");
    set_wr(0, 3, 15'h1234, 2'd2, 8'h05, 1, 22'h2ABCD, 2'd3, 0, 1, 0, 0);
    inv_all = 1;
    tick("R9 write with invalidate");
    look(mkva(15'h1234, 3, 2'd2, 10'h1A5), "R9 write cancelled by invalidate");

    // random traffic over a small tag space
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(99) < 30)
        set_wr(2'($urandom_range(3)), 5'($urandom_range(3)), 15'($urandom_range(3)),
               2'($urandom_range(3)), 8'($urandom_range(3)), 1'($urandom_range(9) != 0),
               22'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      if ($urandom_range(99) < 60) begin
        req_vld = 1;
        req_va = mkva(15'($urandom_range(3)), 5'($urandom_range(3)), 2'($urandom), 10'($urandom));
      end
      if ($urandom_range(199) == 0) inv_all = 1;
      if ($urandom_range(49) == 0) mode_single = ~mode_single;
      if ($urandom_range(19) == 0) cur_asid = 8'($urandom_range(3));
      tick("R3 R4 R5 R6 R7 R10 R11 R12 random");
    end

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule